// File: doc/BRIEF.md
# Packed SIMD Lane Compare Unit

This block is the compare stage of a 64-bit packed-integer datapath. Each cycle it may accept two resolved operands and the second byte of a compare instruction. That byte chooses the lane width (8, 16 or 32 bits) and the test to apply: equality, or signed greater-than of the destination operand over the source.

The block produces a 64-bit mask. Each lane of the mask is filled with ones where the test holds and with zeros where it fails. The result is registered, so it appears with a valid flag on the cycle after issue. A new operation can be accepted on every cycle.

An opcode byte that is not one of the five compare encodings gives no result. Instead it raises an illegal flag for one cycle. Fetching operands from memory, decoding addressing bytes and writing the result back to a register file are all handled outside this block.

Top module: `simd_lane_cmp`

## Requirements
- R1: While `rst_ni` is low, `valid_o` and `illegal_o` are 0 and `mask_o` is all zeros, and this takes effect without waiting for a clock edge.
- R2: Opcode 8'h76 compares 32-bit lanes for equality. Lane k is bits [32k+31:32k]. Each mask lane is 32'hFFFFFFFF where `lhs_i` equals `rhs_i` and 32'h0 otherwise.
- R3: Opcode 8'h75 compares 16-bit lanes (bits [16k+15:16k]) for equality. Each mask lane is 16'hFFFF on a match and 16'h0000 otherwise.
- R4: Opcode 8'h64 tests each 8-bit lane (bits [8k+7:8k]) for `lhs_i` > `rhs_i`, with both values read as two's-complement signed. The mask lane is 8'hFF when the test holds and 8'h00 otherwise, so equal lanes give 8'h00.
- R5: Opcode 8'h65 applies the same signed greater-than test to 16-bit lanes, and opcode 8'h66 applies it to 32-bit lanes.
- R6: A legal issue (`valid_i` high with one of the five opcodes) gives `valid_o` high with its mask on the very next cycle. Issues on consecutive cycles each produce a result on consecutive cycles.
- R7: An issue with any other opcode sets `illegal_o` on the next cycle with `valid_o` low. It leaves `mask_o` unchanged. `valid_o` and `illegal_o` are never high together.
- R8: A cycle with no legal issue drives `valid_o` low on the next cycle and leaves `mask_o` holding the last result.
- R9: Every mask lane is uniform: for the selected lane width, each lane is either all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| opc_i | input | 8 | Second opcode byte selecting lane width and test |
| lhs_i | input | 64 | Destination operand (left side of the test) |
| rhs_i | input | 64 | Source operand (right side of the test) |
| valid_o | output | 1 | Result valid, one cycle after a legal issue |
| illegal_o | output | 1 | Unrecognised opcode, one cycle after issue |
| mask_o | output | 64 | Per-lane compare mask |

## Verification
The checker enforces several properties on every cycle:
- the one-cycle timing of `valid_o` and `illegal_o`;
- the rule that the two flags are mutually exclusive;
- that the mask holds across idle and illegal cycles;
- that mask lanes are uniform at word and doubleword width;
- that identical operands give all ones for equality and all zeros for greater-than.

Whether a given lane's answer is correct can only be shown by the bench's scenarios. These include signed boundary pairs such as 8'h80 against 8'h7F, mixed match and mismatch lanes, and pseudo-random streams across all five opcodes. The bench also covers a reset applied in the middle of operation.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  typedef enum logic [1:0] {
    LW_BYTE  = 2'd0,
    LW_WORD  = 2'd1,
    LW_DWORD = 2'd2
  } lane_sz_e;

  typedef enum logic {
    OP_EQ = 1'b0,
    OP_GT = 1'b1
  } cmp_kind_e;

  typedef struct packed {
    logic      legal;
    lane_sz_e  sz;
    cmp_kind_e kind;
  } cmp_dec_t;

  localparam int unsigned NUM_SZ    = 3;
  localparam int unsigned MIN_LANE_W = 8;

endpackage

// File: rtl/simd_cmp_decode.sv
module simd_cmp_decode
  import simd_cmp_pkg::*;
#(
  parameter logic [7:0] OPC_GT_B = 8'h64,
  parameter logic [7:0] OPC_GT_W = 8'h65,
  parameter logic [7:0] OPC_GT_D = 8'h66,
  parameter logic [7:0] OPC_EQ_W = 8'h75,
  parameter logic [7:0] OPC_EQ_D = 8'h76
) (
  input  logic [7:0] opc_i,
  output cmp_dec_t   dec_o
);

  always_comb begin
    dec_o = '{legal: 1'b0, sz: LW_BYTE, kind: OP_EQ};
    unique case (opc_i)
      OPC_GT_B: dec_o = '{legal: 1'b1, sz: LW_BYTE,  kind: OP_GT};
      OPC_GT_W: dec_o = '{legal: 1'b1, sz: LW_WORD,  kind: OP_GT};
      OPC_GT_D: dec_o = '{legal: 1'b1, sz: LW_DWORD, kind: OP_GT};
      OPC_EQ_W: dec_o = '{legal: 1'b1, sz: LW_WORD,  kind: OP_EQ};
      OPC_EQ_D: dec_o = '{legal: 1'b1, sz: LW_DWORD, kind: OP_EQ};
      default:  dec_o = '{legal: 1'b0, sz: LW_BYTE,  kind: OP_EQ};
    endcase
  end

endmodule

// File: rtl/simd_cmp_lanes.sv
module simd_cmp_lanes #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  output logic [DATA_W-1:0] eq_mask_o,
  output logic [DATA_W-1:0] gt_mask_o
);

  localparam int unsigned NUM_LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic signed [LANE_W-1:0] a_s, b_s;
    assign a_s = $signed(lhs_i[g*LANE_W +: LANE_W]);
    assign b_s = $signed(rhs_i[g*LANE_W +: LANE_W]);
    assign eq_mask_o[g*LANE_W +: LANE_W] = {LANE_W{a_s == b_s}};
    assign gt_mask_o[g*LANE_W +: LANE_W] = {LANE_W{a_s > b_s}};
  end

endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
  import simd_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opc_i,
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] mask_o
);

  cmp_dec_t dec;

  simd_cmp_decode u_dec (
    .opc_i (opc_i),
    .dec_o (dec)
  );

  logic [DATA_W-1:0] eq_m [NUM_SZ];
  logic [DATA_W-1:0] gt_m [NUM_SZ];

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_width
    simd_cmp_lanes #(
      .DATA_W (DATA_W),
      .LANE_W (MIN_LANE_W << s)
    ) u_lanes (
      .lhs_i     (lhs_i),
      .rhs_i     (rhs_i),
      .eq_mask_o (eq_m[s]),
      .gt_mask_o (gt_m[s])
    );
  end

  logic [DATA_W-1:0] eq_sel, gt_sel, mask_d;

  always_comb begin
    unique case (dec.sz)
      LW_WORD:  begin eq_sel = eq_m[1]; gt_sel = gt_m[1]; end
      LW_DWORD: begin eq_sel = eq_m[2]; gt_sel = gt_m[2]; end
      default:  begin eq_sel = eq_m[0]; gt_sel = gt_m[0]; end
    endcase
    mask_d = (dec.kind == OP_GT) ? gt_sel : eq_sel;
  end

  logic              valid_q, illegal_q;
  logic [DATA_W-1:0] mask_q;
  logic              issue_ok;

  assign issue_ok = valid_i & dec.legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      mask_q    <= '0;
    end else begin
      valid_q   <= issue_ok;
      illegal_q <= valid_i & ~dec.legal;
      if (issue_ok) mask_q <= mask_d;
    end
  end

  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;
  assign mask_o    = mask_q;

endmodule

// File: rtl/simd_lane_cmp_chk.sv
module simd_lane_cmp_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        opc_i,
  input logic [DATA_W-1:0] lhs_i,
  input logic [DATA_W-1:0] rhs_i,
  input logic              valid_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] mask_o
);

  localparam int unsigned NBYTES = DATA_W / 8;

  function automatic logic known_opc(input logic [7:0] o);
    return (o == 8'h64) || (o == 8'h65) || (o == 8'h66) ||
           (o == 8'h75) || (o == 8'h76);
  endfunction

  function automatic logic uniform(input logic [DATA_W-1:0] m, input int unsigned bytes);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NBYTES; i++) begin
      if (m[i*8 +: 8] != 8'h00 && m[i*8 +: 8] != 8'hFF) ok = 1'b0;
      if ((i % bytes) != 0 && m[i*8 +: 8] != m[(i-1)*8 +: 8]) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_LEGAL_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && known_opc(opc_i) |=> valid_o && !illegal_o); // R6

  AST_ILLEGAL_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !known_opc(opc_i) |=> illegal_o && !valid_o); // R7

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !illegal_o); // R8

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && known_opc(opc_i)) |=> $stable(mask_o)); // R8

  AST_DEQ_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opc_i == 8'h76 && lhs_i == rhs_i |=> mask_o == '1); // R2

  AST_WEQ_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opc_i == 8'h75 && lhs_i == rhs_i |=> mask_o == '1); // R3

  AST_GT_STRICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (opc_i == 8'h64 || opc_i == 8'h65 || opc_i == 8'h66) &&
    lhs_i == rhs_i |=> mask_o == '0); // R4

  AST_UNIFORM_W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (opc_i == 8'h65 || opc_i == 8'h75) |=> uniform(mask_o, 2)); // R9

  AST_UNIFORM_D: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (opc_i == 8'h66 || opc_i == 8'h76) |=> uniform(mask_o, 4)); // R9

  AST_UNIFORM_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> uniform(mask_o, 1)); // R9

endmodule

bind simd_lane_cmp simd_lane_cmp_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/simd_lane_cmp_test.sv
module simd_lane_cmp_test;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [7:0]  opc_i;
  logic [63:0] lhs_i, rhs_i;
  logic        valid_o, illegal_o;
  logic [63:0] mask_o;

  always #10 clk_i = ~clk_i;

  simd_lane_cmp uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .opc_i     (opc_i),
    .lhs_i     (lhs_i),
    .rhs_i     (rhs_i),
    .valid_o   (valid_o),
    .illegal_o (illegal_o),
    .mask_o    (mask_o)
  );

  typedef struct {
    logic        v;
    logic        ill;
    logic [63:0] m;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [63:0] model_mask = '0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  function automatic bit ref_legal(input logic [7:0] o);
    return o inside {8'h64, 8'h65, 8'h66, 8'h75, 8'h76};
  endfunction

  function automatic logic [63:0] ref_mask(input logic [7:0] o, input logic [63:0] a, input logic [63:0] b);
    int w;
    bit gt;
    logic [63:0] r;
    case (o)
      8'h64:   begin w = 8;  gt = 1; end
      8'h65:   begin w = 16; gt = 1; end
      8'h66:   begin w = 32; gt = 1; end
      8'h75:   begin w = 16; gt = 0; end
      default: begin w = 32; gt = 0; end
    endcase
    r = '0;
    for (int k = 0; k < 64 / w; k++) begin
      logic signed [63:0] sa, sb_v;
      bit hit;
      sa   = $signed(a << (64 - (k + 1) * w)) >>> (64 - w);
      sb_v = $signed(b << (64 - (k + 1) * w)) >>> (64 - w);
      hit  = gt ? (sa > sb_v) : (sa == sb_v);
      if (hit) r = r | ((((64'h1 << w) - 64'h1)) << (k * w));
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // driver: one item per cycle
  task automatic issue(input logic v, input logic [7:0] o, input logic [63:0] a,
                       input logic [63:0] b, input string req);
    exp_t e;
    @(negedge clk_i);
    valid_i = v; opc_i = o; lhs_i = a; rhs_i = b;
    if (v && ref_legal(o)) begin
      model_mask = ref_mask(o, a, b);
      e = '{v: 1'b1, ill: 1'b0, m: model_mask, req: req};
    end else if (v) begin
      e = '{v: 1'b0, ill: 1'b1, m: model_mask, req: req};
    end else begin
      e = '{v: 1'b0, ill: 1'b0, m: model_mask, req: req};
    end
    sb.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (mon_on && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(valid_o === e.v && illegal_o === e.ill && mask_o === e.m, e.req,
            $sformatf("actual v=%b ill=%b mask=%h expected v=%b ill=%b mask=%h",
                      valid_o, illegal_o, mask_o, e.v, e.ill, e.m));
    end
  end

  task automatic drain();
    issue(1'b0, 8'h00, '0, '0, "R8");
    @(posedge clk_i); #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    logic [7:0]  ops [5];
    ops = '{8'h64, 8'h65, 8'h66, 8'h75, 8'h76};
    rst_ni = 1'b0; valid_i = 1'b0; opc_i = '0; lhs_i = '0; rhs_i = '0;
    #35;
    check(valid_o === 1'b0 && illegal_o === 1'b0 && mask_o === '0, "R1",
          $sformatf("actual v=%b ill=%b mask=%h expected 0 0 0", valid_o, illegal_o, mask_o));
    @(negedge clk_i); rst_ni = 1'b1; mon_on = 1'b1;

    // R2: dword equality, mixed lanes
    issue(1, 8'h76, 64'h1234_5678_DEAD_BEEF, 64'h1234_5678_DEAD_BEEE, "R2");
    issue(1, 8'h76, 64'hCAFE_F00D_0000_0001, 64'hCAFE_F00D_0000_0001, "R2");
    // R3: word equality
    issue(1, 8'h75, 64'hAAAA_0001_BBBB_0002, 64'hAAAA_0000_BBBB_0002, "R3");
    // R4: signed byte greater-than boundaries
    issue(1, 8'h64, 64'h807F_00FF_0105_FE10, 64'h7F80_FF00_0104_FF0F, "R4");
    issue(1, 8'h64, 64'h1111_1111_1111_1111, 64'h1111_1111_1111_1111, "R4");
    // R5: word and dword greater-than
    issue(1, 8'h65, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_0000, "R5");
    issue(1, 8'h66, 64'h8000_0000_0000_0002, 64'h7FFF_FFFF_FFFF_FFFF, "R5");
    issue(1, 8'h66, 64'h7FFF_FFFF_0000_0000, 64'h8000_0000_0000_0001, "R5");
    // R7: illegal opcodes between legal ones, mask held
    issue(1, 8'h74, 64'h0, 64'h0, "R7");
    issue(1, 8'h67, 64'h1, 64'h0, "R7");
    issue(1, 8'h76, 64'h5, 64'h5, "R7");
    issue(1, 8'h00, 64'h0, 64'h0, "R7");
    issue(1, 8'hFF, 64'h0, 64'h0, "R7");
    // R8: idle cycles with changing inputs keep mask
    issue(0, 8'h64, 64'hFF, 64'h00, "R8");
    issue(0, 8'h76, 64'h00, 64'h00, "R8");
    // R6/R9: back-to-back pseudo-random stream over all opcodes
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      a = lfsr;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      b = (i % 3 == 0) ? (a ^ (64'hFF << ((i % 8) * 8))) : lfsr;
      issue(1, ops[i % 5], a, b, (i % 2) ? "R6" : "R9");
    end
    drain();

    // R1: reset in mid-operation
    issue(1, 8'h76, 64'h0, 64'h0, "R1");
    @(posedge clk_i); #2;
    @(negedge clk_i); rst_ni = 1'b0; mon_on = 1'b0; sb.delete();
    #1;
    check(valid_o === 1'b0 && illegal_o === 1'b0 && mask_o === '0, "R1",
          $sformatf("actual v=%b ill=%b mask=%h expected 0 0 0", valid_o, illegal_o, mask_o));
    model_mask = '0;
    @(negedge clk_i); rst_ni = 1'b1; mon_on = 1'b1;
    issue(1, 8'h65, 64'h0001_0000_0000_0000, 64'h0, "R1");
    drain();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule